// File: doc/BRIEF.md
# Chained-Reload DMA Channel Controller

This block controls one DMA channel. Software programs it through a three-word register window: a control/status word, a current address and a current byte count. Behind the address and count sit a second "next" address and "next" count. When the current count runs out, the channel can copy that pair into the current registers and continue, so two buffers run back to back without software stepping in.

A device asks for service on a request line. While the channel is running, it asks memory for word beats and reports a burst length. Each acknowledged beat is passed back to the device as an acknowledge. Each beat moves the address up by four and the count down by four. An interrupt line reports terminal count. The memory bus protocol and the data FIFO live outside this block. Only the beat handshake is modelled here.

Top module: `dma_chain_channel`

## Requirements
- R1: The register window has three words. Byte offset 0 is control/status, offset 4 is the address and offset 8 is the byte count. Reads at offsets 4 and 8 always return the current (not the next) address and count. The two low bits of the count are not stored and read as 0. Any other offset reads 0, and writes to it change nothing.
- R2: Control bit 24 is the chain enable. While it is 1, writes to offsets 4 and 8 load the next address and next count, and a write to offset 4 sets status bit 27 (next loaded). While it is 0, those writes load the current registers, and a write to offset 4 sets status bit 26 (current loaded).
- R3: After the synchronous reset, bits 31:28 of the control/status word read 0xC, bit 10 reads the live device request, and every other bit is 0. The address and count both read 0.
- R4: The memory request output `mem_req` is high only when all of the following hold:
  - bit 9 (run) is 1;
  - bit 7 (soft reset) is 0;
  - bit 26 is 1;
  - `dev_req` is high;
  - bit 13 (count enable) is 0, or the count is at least 4.
  Status bit 25 reads as run AND NOT soft reset AND bit 26.
- R5: Each cycle in which `mem_ack` and `mem_req` are both high is one beat.
  - A beat pulses `dev_ack` in the same cycle.
  - A beat adds 4 to the address.
  - If bit 13 is set, a beat subtracts 4 from the count.
  - `mem_ack` has no effect while `mem_req` is low.
  - `mem_write` follows bit 8 (1 means device to memory).
- R6: `mem_burst` gives the burst length coded in bits 19:18: 00 is 4 words, 01 is 8 words, 10 is 1 word and 11 is 16 words. When bit 13 is set, the value is capped at the number of remaining words.
- R7: A beat that brings the count to zero while bit 13 is set sets bit 14 (terminal count). Writing 1 to bit 14 clears it.
- R8: On that same beat, the next address and count are copied into the current registers if bits 24, 13 and 27 are all set. Bit 27 then clears, and `mem_req` stays high in the following cycle without a gap. When bit 13 is 0, bit 24 causes no reload.
- R9: Terminal count sets bit 0 (interrupt pending) unless bit 23 (terminal-count interrupt suppress) is set. `irq` equals bit 0 AND bit 4 (interrupt enable). Writing 1 to bit 0 clears it, and a new terminal count in the same cycle takes priority over that clear.
- R10: Bit 7 (soft reset) stays 1 until software writes 0 to it. While it is 1:
  - `mem_req` stays low;
  - bits 26, 27, 14 and 0 are held at 0.
  Bit 10 always reports `dev_req`, so software can see whether releasing soft reset is safe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_ofs` (combinational) |
| dev_req | input | 1 | Device service request |
| dev_ack | output | 1 | Beat acknowledge to the device |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | ADDR_W (32) | Current beat address |
| mem_write | output | 1 | Direction: 1 device to memory, 0 memory to device |
| mem_burst | output | 5 | Words allowed in the present burst |
| mem_ack | input | 1 | Memory beat acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, these properties of a single beat:
- a terminal-count beat raises bit 14 and, unless suppressed, bit 0 in the next cycle;
- a reload moves the next count into the current count and drops bit 27;
- an ordinary beat advances the address by four;
- the burst length never exceeds the coded length or the remaining words;
- no request appears while the channel is stopped or in soft reset.

Only the bench scenarios can show the behaviours that span several register accesses:
- where writes land when chain enable is set;
- the write-one-to-clear ordering of the status flags;
- the absence of a gap across a chained reload;
- the fact that soft reset stays held until it is written to 0.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int unsigned REG_W = 32;
    localparam logic [3:0]  DEV_ID = 4'hC;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_ADDR  = 4'h4;
    localparam logic [3:0] OFS_COUNT = 4'h8;

    // control/status bit positions
    localparam int B_IRQ_PEND  = 0;
    localparam int B_IRQ_EN    = 4;
    localparam int B_SOFT_RST  = 7;
    localparam int B_DIR       = 8;
    localparam int B_RUN       = 9;
    localparam int B_REQ_SEEN  = 10;
    localparam int B_CNT_EN    = 13;
    localparam int B_TERM      = 14;
    localparam int B_BURST_LO  = 18;
    localparam int B_TC_QUIET  = 23;
    localparam int B_CHAIN     = 24;
    localparam int B_ACTIVE    = 25;
    localparam int B_CUR_VALID = 26;
    localparam int B_NXT_VALID = 27;
    localparam int B_ID_LO     = 28;

    typedef enum logic [1:0] {
        BURST_W4  = 2'b00,
        BURST_W8  = 2'b01,
        BURST_W1  = 2'b10,
        BURST_W16 = 2'b11
    } burst_code_e;

    typedef struct packed {
        logic        chain_en;
        logic        tc_quiet;
        burst_code_e burst;
        logic        cnt_en;
        logic        run_en;
        logic        dir_to_mem;
        logic        soft_rst;
        logic        irq_en;
    } ctrl_t;

    typedef struct packed {
        logic nxt_valid;
        logic cur_valid;
        logic term;
        logic irq_pend;
    } flags_t;

    function automatic logic [4:0] burst_words(burst_code_e code);
        case (code)
            BURST_W4:  return 5'd4;
            BURST_W8:  return 5'd8;
            BURST_W1:  return 5'd1;
            default:   return 5'd16;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(logic [REG_W-1:0] w);
        ctrl_t c;
        c.chain_en   = w[B_CHAIN];
        c.tc_quiet   = w[B_TC_QUIET];
        c.burst      = burst_code_e'(w[B_BURST_LO +: 2]);
        c.cnt_en     = w[B_CNT_EN];
        c.run_en     = w[B_RUN];
        c.dir_to_mem = w[B_DIR];
        c.soft_rst   = w[B_SOFT_RST];
        c.irq_en     = w[B_IRQ_EN];
        return c;
    endfunction

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    localparam int WCNT_W = CNT_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_ofs,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              beat,
    output ctrl_t             ctrl_q,
    output flags_t            flags_q,
    output logic [ADDR_W-1:0] cur_addr_q,
    output logic [WCNT_W-1:0] cur_words_q
);

    logic [ADDR_W-1:0] nxt_addr_q;
    logic [WCNT_W-1:0] nxt_words_q;
    flags_t            flags_d;

    logic wr_ctrl, wr_addr, wr_cnt, to_shadow;
    logic term_evt, do_reload;

    assign wr_ctrl   = wr_en && (wr_ofs == OFS_CTRL);
    assign wr_addr   = wr_en && (wr_ofs == OFS_ADDR);
    assign wr_cnt    = wr_en && (wr_ofs == OFS_COUNT);
    assign to_shadow = ctrl_q.chain_en;

    assign term_evt  = beat && ctrl_q.cnt_en && (cur_words_q == WCNT_W'(1));
    assign do_reload = term_evt && ctrl_q.chain_en && flags_q.nxt_valid;

    always_comb begin
        flags_d = flags_q;
        if (do_reload)                      flags_d.nxt_valid = 1'b0;
        if (wr_addr && to_shadow)           flags_d.nxt_valid = 1'b1;
        if (wr_addr && !to_shadow)          flags_d.cur_valid = 1'b1;
        if (wr_ctrl && wr_data[B_TERM])     flags_d.term      = 1'b0;
        if (wr_ctrl && wr_data[B_IRQ_PEND]) flags_d.irq_pend  = 1'b0;
        if (term_evt)                       flags_d.term      = 1'b1;
        if (term_evt && !ctrl_q.tc_quiet)   flags_d.irq_pend  = 1'b1;
        if (ctrl_q.soft_rst)                flags_d           = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            flags_q     <= '0;
            cur_addr_q  <= '0;
            cur_words_q <= '0;
            nxt_addr_q  <= '0;
            nxt_words_q <= '0;
        end else begin
            flags_q <= flags_d;
            if (wr_ctrl)
                ctrl_q <= ctrl_from_word(wr_data);

            if (wr_addr && !to_shadow)
                cur_addr_q <= wr_data[ADDR_W-1:0];
            else if (do_reload)
                cur_addr_q <= nxt_addr_q;
            else if (beat)
                cur_addr_q <= cur_addr_q + ADDR_W'(4);

            if (wr_cnt && !to_shadow)
                cur_words_q <= wr_data[CNT_W-1:2];
            else if (do_reload)
                cur_words_q <= nxt_words_q;
            else if (beat && ctrl_q.cnt_en)
                cur_words_q <= cur_words_q - WCNT_W'(1);

            if (wr_addr && to_shadow)
                nxt_addr_q <= wr_data[ADDR_W-1:0];
            if (wr_cnt && to_shadow)
                nxt_words_q <= wr_data[CNT_W-1:2];
        end
    end

    // R7: a zeroing beat raises terminal count
    assert_term_sets_R7: assert property (@(posedge clk) disable iff (rst)
        term_evt |=> flags_q.term);

    // R9: terminal count raises interrupt pending unless suppressed
    assert_irq_pend_R9: assert property (@(posedge clk) disable iff (rst)
        (term_evt && !ctrl_q.tc_quiet) |=> flags_q.irq_pend);

    // R8: reload moves the shadow count in and drops next-loaded
    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (do_reload && !wr_en) |=> (cur_words_q == $past(nxt_words_q)) && !flags_q.nxt_valid);

    // R5: an ordinary beat steps the address by one word
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (beat && !do_reload && !wr_addr) |=> cur_addr_q == $past(cur_addr_q) + ADDR_W'(4));

    // R10: soft reset clears the loaded flags
    assert_softrst_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.soft_rst |=> !flags_q.cur_valid && !flags_q.nxt_valid);

endmodule

// File: rtl/dma_chain_beat.sv
module dma_chain_beat
    import dma_chain_pkg::*;
#(
    parameter int WCNT_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              cur_valid,
    input  logic [WCNT_W-1:0] cur_words,
    input  logic              dev_req,
    input  logic              mem_ack,
    output logic              active,
    output logic              mem_req,
    output logic [4:0]        mem_burst,
    output logic              beat
);

    logic       have_words;
    logic [4:0] coded;

    assign active     = ctrl.run_en && !ctrl.soft_rst && cur_valid;
    assign have_words = !ctrl.cnt_en || (cur_words != '0);
    assign mem_req    = active && dev_req && have_words;
    assign beat       = mem_req && mem_ack;
    assign coded      = burst_words(ctrl.burst);

    always_comb begin
        if (ctrl.cnt_en && (cur_words < WCNT_W'(coded)))
            mem_burst = 5'(cur_words);
        else
            mem_burst = coded;
    end

    // R6: burst never exceeds the coded length
    assert_burst_coded_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_burst != 5'd0) && (mem_burst <= burst_words(ctrl.burst)));

    // R6: burst never exceeds the remaining words
    assert_burst_remain_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && ctrl.cnt_en) |-> (WCNT_W'(mem_burst) <= cur_words));

endmodule

// File: rtl/dma_chain_rdmux.sv
module dma_chain_rdmux
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    localparam int WCNT_W = CNT_W - 2
) (
    input  logic [3:0]        ofs,
    input  ctrl_t             ctrl,
    input  flags_t            flags,
    input  logic              active,
    input  logic              dev_req,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [WCNT_W-1:0] cur_words,
    output logic [REG_W-1:0]  rdata
);

    logic [REG_W-1:0] csr_word;

    always_comb begin
        csr_word                  = '0;
        csr_word[B_ID_LO +: 4]    = DEV_ID;
        csr_word[B_IRQ_PEND]      = flags.irq_pend;
        csr_word[B_IRQ_EN]        = ctrl.irq_en;
        csr_word[B_SOFT_RST]      = ctrl.soft_rst;
        csr_word[B_DIR]           = ctrl.dir_to_mem;
        csr_word[B_RUN]           = ctrl.run_en;
        csr_word[B_REQ_SEEN]      = dev_req;
        csr_word[B_CNT_EN]        = ctrl.cnt_en;
        csr_word[B_TERM]          = flags.term;
        csr_word[B_BURST_LO +: 2] = ctrl.burst;
        csr_word[B_TC_QUIET]      = ctrl.tc_quiet;
        csr_word[B_CHAIN]         = ctrl.chain_en;
        csr_word[B_ACTIVE]        = active;
        csr_word[B_CUR_VALID]     = flags.cur_valid;
        csr_word[B_NXT_VALID]     = flags.nxt_valid;
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_CTRL:  rdata = csr_word;
            OFS_ADDR:  rdata[ADDR_W-1:0] = cur_addr;
            OFS_COUNT: rdata[CNT_W-1:0]  = {cur_words, 2'b00};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_ofs,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic [4:0]        mem_burst,
    input  logic              mem_ack,
    output logic              irq
);

    localparam int WCNT_W = CNT_W - 2;

    ctrl_t             ctrl;
    flags_t            flags;
    logic [ADDR_W-1:0] cur_addr;
    logic [WCNT_W-1:0] cur_words;
    logic              beat, active;

    dma_chain_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .wr_ofs     (reg_ofs),
        .wr_data    (reg_wdata),
        .beat       (beat),
        .ctrl_q     (ctrl),
        .flags_q    (flags),
        .cur_addr_q (cur_addr),
        .cur_words_q(cur_words)
    );

    dma_chain_beat #(.WCNT_W(WCNT_W)) u_beat (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .cur_valid(flags.cur_valid),
        .cur_words(cur_words),
        .dev_req  (dev_req),
        .mem_ack  (mem_ack),
        .active   (active),
        .mem_req  (mem_req),
        .mem_burst(mem_burst),
        .beat     (beat)
    );

    dma_chain_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rdmux (
        .ofs      (reg_ofs),
        .ctrl     (ctrl),
        .flags    (flags),
        .active   (active),
        .dev_req  (dev_req),
        .cur_addr (cur_addr),
        .cur_words(cur_words),
        .rdata    (reg_rdata)
    );

    assign dev_ack   = beat;
    assign mem_addr  = cur_addr;
    assign mem_write = ctrl.dir_to_mem;
    assign irq       = flags.irq_pend && ctrl.irq_en;

    // R4: a stopped, held or unloaded channel never requests
    assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run_en || ctrl.soft_rst || !flags.cur_valid) |-> !mem_req);

    // R5: the device only sees acknowledges for requested beats
    assert_ack_R5: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> (mem_req && mem_ack));

endmodule

// File: tb/dma_chain_channel_bench.sv
`timescale 1ns/1ps
module dma_chain_channel_bench;

    localparam int ADDR_W = 32;
    localparam logic [31:0] C_RUN   = 32'h0000_0200;
    localparam logic [31:0] C_CNT   = 32'h0000_2000;
    localparam logic [31:0] C_DIR   = 32'h0000_0100;
    localparam logic [31:0] C_IEN   = 32'h0000_0010;
    localparam logic [31:0] C_SRST  = 32'h0000_0080;
    localparam logic [31:0] C_QUIET = 32'h0080_0000;
    localparam logic [31:0] C_CHAIN = 32'h0100_0000;
    localparam logic [31:0] S_IPEND = 32'h0000_0001;
    localparam logic [31:0] S_TERM  = 32'h0000_4000;
    localparam logic [31:0] S_REQ   = 32'h0000_0400;
    localparam logic [31:0] S_CUR   = 32'h0400_0000;
    localparam logic [31:0] S_NXT   = 32'h0800_0000;

    typedef struct packed {
        logic [1:0]  code;
        logic [31:0] bytes;
        logic        cnt_en;
        logic [4:0]  exp_burst;
        logic        exp_req;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'd40,  1'b1, 5'd4,  1'b1},
        '{2'd1, 32'd40,  1'b1, 5'd8,  1'b1},
        '{2'd2, 32'd40,  1'b1, 5'd1,  1'b1},
        '{2'd3, 32'd40,  1'b1, 5'd10, 1'b1},
        '{2'd3, 32'd100, 1'b1, 5'd16, 1'b1},
        '{2'd1, 32'd12,  1'b1, 5'd3,  1'b1},
        '{2'd3, 32'd8,   1'b0, 5'd16, 1'b1},
        '{2'd0, 32'd0,   1'b1, 5'd0,  1'b0},
        '{2'd0, 32'd2,   1'b1, 5'd0,  1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [3:0] reg_ofs = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic dev_req = 1'b0;
    logic dev_ack, mem_req, mem_write, mem_ack = 1'b0, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [4:0] mem_burst;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;
    logic ack_seen;

    always #2 clk = ~clk;

    dma_chain_channel u_dma_chain_channel (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .dev_ack(dev_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_burst(mem_burst), .mem_ack(mem_ack),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [31:0] data);
        @(negedge clk);
        reg_ofs = ofs; reg_wdata = data; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ofs, output logic [31:0] data);
        @(negedge clk);
        reg_ofs = ofs;
        #1 data = reg_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        mem_ack = 1'b1;
        #1 ack_seen = dev_ack;
        @(posedge clk);
        #1 mem_ack = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        rd(4'h0, rv); chk("R3 csr after reset", rv, 32'hC000_0000);
        dev_req = 1'b1;
        rd(4'h0, rv); chk("R3 R10 csr shows live request", rv, 32'hC000_0400);
        rd(4'h4, rv); chk("R3 address after reset", rv, 32'h0);
        rd(4'h8, rv); chk("R3 count after reset", rv, 32'h0);
        chk("R3 no request after reset", 32'(mem_req), 32'd0);

        // burst coding table
        for (int i = 0; i < NVEC; i++) begin
            wr(4'h0, C_RUN | (VECS[i].cnt_en ? C_CNT : 32'h0) | (32'(VECS[i].code) << 18));
            wr(4'h4, 32'h1000);
            wr(4'h8, VECS[i].bytes);
            settle();
            chk($sformatf("R4 vec%0d request", i), 32'(mem_req), 32'(VECS[i].exp_req));
            if (VECS[i].exp_req)
                chk($sformatf("R6 vec%0d burst", i), 32'(mem_burst), 32'(VECS[i].exp_burst));
        end
        rd(4'h8, rv); chk("R1 count low bits dropped", rv, 32'h0);

        // beats, direction, terminal count
        wr(4'h0, C_RUN | C_CNT | C_DIR | (32'd2 << 18));
        wr(4'h4, 32'h2000);
        wr(4'h8, 32'd12);
        settle(); chk("R5 direction output", 32'(mem_write), 32'd1);
        pulse_ack(); chk("R5 dev_ack on beat", 32'(ack_seen), 32'd1);
        rd(4'h4, rv); chk("R5 address stepped", rv, 32'h2004);
        rd(4'h8, rv); chk("R5 count stepped", rv, 32'd8);
        dev_req = 1'b0;
        pulse_ack(); chk("R5 no ack without request", 32'(ack_seen), 32'd0);
        rd(4'h8, rv); chk("R5 ack ignored when idle", rv, 32'd8);
        dev_req = 1'b1;
        pulse_ack(); pulse_ack();
        rd(4'h0, rv); chk("R7 terminal count set", rv & S_TERM, S_TERM);
        chk("R9 interrupt pending set", rv & S_IPEND, S_IPEND);
        chk("R4 stops at zero count", 32'(mem_req), 32'd0);
        chk("R9 irq masked", 32'(irq), 32'd0);
        wr(4'h0, C_RUN | C_CNT | C_DIR | (32'd2 << 18) | C_IEN);
        settle(); chk("R9 irq when enabled", 32'(irq), 32'd1);
        wr(4'h0, C_RUN | C_CNT | C_DIR | (32'd2 << 18) | C_IEN | S_TERM);
        rd(4'h0, rv); chk("R7 terminal count cleared by one", rv & S_TERM, 32'h0);
        chk("R9 irq survives term clear", 32'(irq), 32'd1);
        wr(4'h0, C_RUN | C_CNT | C_DIR | (32'd2 << 18) | C_IEN | S_IPEND);
        settle(); chk("R9 pending cleared by one", 32'(irq), 32'd0);

        // suppressed terminal-count interrupt
        wr(4'h0, C_RUN | C_CNT | C_IEN | C_QUIET);
        wr(4'h4, 32'h2100);
        wr(4'h8, 32'd4);
        pulse_ack();
        rd(4'h0, rv); chk("R9 suppress keeps term", rv & S_TERM, S_TERM);
        chk("R9 suppress blocks pending", rv & S_IPEND, 32'h0);
        chk("R9 suppress irq low", 32'(irq), 32'd0);

        // chained reload
        wr(4'h0, C_RUN | C_CNT | (32'd1 << 18) | S_TERM);
        wr(4'h4, 32'h3000);
        wr(4'h8, 32'd4);
        wr(4'h0, C_RUN | C_CNT | (32'd1 << 18) | C_CHAIN);
        wr(4'h4, 32'h5000);
        wr(4'h8, 32'd8);
        rd(4'h0, rv); chk("R2 next loaded flag", rv & S_NXT, S_NXT);
        rd(4'h4, rv); chk("R2 R1 current address kept", rv, 32'h3000);
        rd(4'h8, rv); chk("R2 R1 current count kept", rv, 32'd4);
        chk("R6 burst capped at one", 32'(mem_burst), 32'd1);
        pulse_ack();
        settle();
        chk("R8 no gap after reload", 32'(mem_req), 32'd1);
        chk("R8 address reloaded", mem_addr, 32'h5000);
        chk("R8 burst from reloaded count", 32'(mem_burst), 32'd2);
        rd(4'h8, rv); chk("R8 count reloaded", rv, 32'd8);
        rd(4'h0, rv); chk("R8 next flag dropped", rv & S_NXT, 32'h0);
        chk("R7 term on chained buffer", rv & S_TERM, S_TERM);
        pulse_ack(); pulse_ack();
        settle();
        chk("R8 stop without shadow", 32'(mem_req), 32'd0);
        chk("R8 address after second buffer", mem_addr, 32'h5008);

        // chain enable without counter enable
        wr(4'h0, C_RUN);
        wr(4'h4, 32'h6000);
        wr(4'h0, C_RUN | C_CHAIN);
        wr(4'h4, 32'h7000);
        wr(4'h8, 32'd4);
        pulse_ack();
        rd(4'h4, rv); chk("R8 no reload without counter", rv, 32'h6004);
        rd(4'h0, rv); chk("R8 shadow kept without counter", rv & S_NXT, S_NXT);

        // soft reset
        wr(4'h0, C_RUN | C_SRST);
        repeat (5) @(posedge clk);
        rd(4'h0, rv);
        chk("R10 soft reset held", rv & C_SRST, C_SRST);
        chk("R10 loaded flags cleared", rv & (S_CUR | S_NXT), 32'h0);
        chk("R10 pending request visible", rv & S_REQ, S_REQ);
        chk("R10 no request in soft reset", 32'(mem_req), 32'd0);
        wr(4'h0, C_RUN);
        rd(4'h0, rv); chk("R10 soft reset released", rv & C_SRST, 32'h0);
        chk("R4 unloaded address blocks request", 32'(mem_req), 32'd0);
        wr(4'h4, 32'h8000);
        rd(4'h0, rv); chk("R2 current loaded flag", rv & S_CUR, S_CUR);
        chk("R4 request after load", 32'(mem_req), 32'd1);

        // run gating
        dev_req = 1'b0;
        settle(); chk("R4 no device request", 32'(mem_req), 32'd0);
        dev_req = 1'b1;
        wr(4'h0, 32'h0);
        settle(); chk("R4 run disabled", 32'(mem_req), 32'd0);
        wr(4'h0, C_RUN);

        // unused offset
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, rv); chk("R1 unused offset reads zero", rv, 32'h0);
        rd(4'h4, rv); chk("R1 unused write harmless addr", rv, 32'h8000);
        rd(4'h0, rv); chk("R1 unused write harmless csr", rv & C_RUN, C_RUN);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule